// File: doc/BRIEF.md
# Cursor Address Counter Unit

This block tracks where a character display memory is being read or written. The cursor position is held as two registers: a row counter and a column counter. Each counter has three decoded command strobes: load a value, step forward and step back. A step that passes the last row or column wraps to the other end.

Whenever a counter is loaded, a matching start register takes the same value. The start registers therefore remember the start point of a transfer, while the live counters move on. A flag shows when the live row equals the start row. A controller uses this flag to end a block transmission.

The memory address is formed from one of two coordinate pairs. It uses the display-refresh coordinates while a refresh access is active, and the cursor coordinates at all other times.

Top module: `cursor_addr_unit`

## Requirements
- R1: After reset, both live counters and both start registers read 0, and `row_match` is 1.
- R2: A load strobe sets the live counter and its start register to the load value on the next clock edge. A value above the limit (79 for the column, 23 for the row) is taken as the limit.
- R3: An up strobe adds 1 to the counter on the next edge. Stepping up from the limit gives 0.
- R4: A down strobe subtracts 1 from the counter on the next edge. Stepping down from 0 gives the limit.
- R5: For one counter, load wins over up, and up wins over down. With no strobe active, the counter keeps its value.
- R6: The start registers change only on a load strobe for their own axis.
- R7: `row_match` is 1 exactly when the live row equals the start row, in the same cycle that the registers show it.
- R8: `ram_addr` equals row × 80 + column. It uses `disp_row`/`disp_col` while `refresh_active` is 1 and the live cursor otherwise, with no register delay.
- R9: The two axes are independent. A column wrap never moves the row, and row commands never move the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_load | input | 1 | Load the row counter |
| row_up | input | 1 | Step the row counter up |
| row_down | input | 1 | Step the row counter down |
| row_load_val | input | 5 | Row load value |
| col_load | input | 1 | Load the column counter |
| col_up | input | 1 | Step the column counter up |
| col_down | input | 1 | Step the column counter down |
| col_load_val | input | 7 | Column load value |
| refresh_active | input | 1 | Display refresh owns the address |
| disp_row | input | 5 | Display line coordinate |
| disp_col | input | 7 | Display character position |
| cur_row | output | 5 | Live cursor row |
| cur_col | output | 7 | Live cursor column |
| start_row | output | 5 | Row captured at the last row load |
| start_col | output | 7 | Column captured at the last column load |
| row_match | output | 1 | Live row equals start row |
| ram_addr | output | 11 | Character memory address |

## Verification
Two kinds of events can fall in the same cycle. The first is competing strobes on one counter. The bench drives all eight load/up/down combinations on both axes at once, from a known state, and compares the result with a priority model. The second is a cursor step while a refresh access holds the address. The bench steps the counters with `refresh_active` high and checks that `ram_addr` follows the display coordinates. It then drops `refresh_active` and checks that the address shows the already-updated cursor.

// File: rtl/cac_pkg.sv
package cac_pkg;

    localparam int CAC_COLS   = 80;
    localparam int CAC_ROWS   = 24;
    localparam int CAC_COL_W  = $clog2(CAC_COLS);
    localparam int CAC_ROW_W  = $clog2(CAC_ROWS);
    localparam int CAC_ADDR_W = $clog2(CAC_COLS * CAC_ROWS);

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2,
        OP_DEC  = 2'd3
    } axis_op_e;

endpackage

// File: rtl/cac_op_decode.sv
module cac_op_decode
    import cac_pkg::*;
(
    input  logic     ld,
    input  logic     up,
    input  logic     dn,
    output axis_op_e op
);

    // load over up over down
    always_comb begin
        if (ld)      op = OP_LOAD;
        else if (up) op = OP_INC;
        else if (dn) op = OP_DEC;
        else         op = OP_KEEP;
    end

endmodule

// File: rtl/cac_axis_counter.sv
module cac_axis_counter
    import cac_pkg::*;
#(
    parameter int W   = 7,
    parameter int MAX = 79
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         up,
    input  logic         dn,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val_o,
    output logic [W-1:0] hold_o
);

    localparam logic [W-1:0] MAX_V = W'(MAX);

    typedef struct packed {
        logic [W-1:0] val;
        logic [W-1:0] hold;
    } axis_st_t;

    axis_st_t st_d, st_q;
    axis_op_e op;
    logic [W-1:0] clip_val;

    cac_op_decode u_dec (
        .ld (ld),
        .up (up),
        .dn (dn),
        .op (op)
    );

    always_comb begin
        clip_val = (ld_val > MAX_V) ? MAX_V : ld_val;
        st_d = st_q;
        case (op)
            OP_LOAD: begin
                st_d.val  = clip_val;
                st_d.hold = clip_val;
            end
            OP_INC:  st_d.val = (st_q.val == MAX_V) ? '0 : st_q.val + W'(1);
            OP_DEC:  st_d.val = (st_q.val == '0) ? MAX_V : st_q.val - W'(1);
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o  = st_q.val;
    assign hold_o = st_q.hold;

    AST_VAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        val_o <= MAX_V);                                                 // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> val_o == (($past(ld_val) > MAX_V) ? MAX_V : $past(ld_val))); // R2
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(hold_o));                                        // R6
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && up && val_o == MAX_V) |=> val_o == '0);                  // R3
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !up && dn && val_o == '0) |=> val_o == MAX_V);           // R4
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !up && !dn) |=> $stable(val_o));                         // R5

endmodule

// File: rtl/cac_addr_select.sv
module cac_addr_select #(
    parameter int COLS   = 80,
    parameter int ROW_W  = 5,
    parameter int COL_W  = 7,
    parameter int ADDR_W = 11
) (
    input  logic              use_disp,
    input  logic [ROW_W-1:0]  cur_row,
    input  logic [COL_W-1:0]  cur_col,
    input  logic [ROW_W-1:0]  disp_row,
    input  logic [COL_W-1:0]  disp_col,
    output logic [ADDR_W-1:0] addr
);

    logic [ROW_W-1:0] sel_row;
    logic [COL_W-1:0] sel_col;

    always_comb begin
        sel_row = use_disp ? disp_row : cur_row;
        sel_col = use_disp ? disp_col : cur_col;
        addr    = ADDR_W'(sel_row) * ADDR_W'(COLS) + ADDR_W'(sel_col);
    end

endmodule

// File: rtl/cursor_addr_unit.sv
module cursor_addr_unit
    import cac_pkg::*;
#(
    parameter int COLS   = CAC_COLS,
    parameter int ROWS   = CAC_ROWS,
    parameter int COL_W  = CAC_COL_W,
    parameter int ROW_W  = CAC_ROW_W,
    parameter int ADDR_W = CAC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_load,
    input  logic              row_up,
    input  logic              row_down,
    input  logic [ROW_W-1:0]  row_load_val,
    input  logic              col_load,
    input  logic              col_up,
    input  logic              col_down,
    input  logic [COL_W-1:0]  col_load_val,
    input  logic              refresh_active,
    input  logic [ROW_W-1:0]  disp_row,
    input  logic [COL_W-1:0]  disp_col,
    output logic [ROW_W-1:0]  cur_row,
    output logic [COL_W-1:0]  cur_col,
    output logic [ROW_W-1:0]  start_row,
    output logic [COL_W-1:0]  start_col,
    output logic              row_match,
    output logic [ADDR_W-1:0] ram_addr
);

    localparam int TOTAL = ROWS * COLS;

    cac_axis_counter #(.W(ROW_W), .MAX(ROWS - 1)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (row_load),
        .up     (row_up),
        .dn     (row_down),
        .ld_val (row_load_val),
        .val_o  (cur_row),
        .hold_o (start_row)
    );

    cac_axis_counter #(.W(COL_W), .MAX(COLS - 1)) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (col_load),
        .up     (col_up),
        .dn     (col_down),
        .ld_val (col_load_val),
        .val_o  (cur_col),
        .hold_o (start_col)
    );

    assign row_match = (cur_row == start_row);

    cac_addr_select #(
        .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
    ) u_sel (
        .use_disp (refresh_active),
        .cur_row  (cur_row),
        .cur_col  (cur_col),
        .disp_row (disp_row),
        .disp_col (disp_col),
        .addr     (ram_addr)
    );

    AST_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |=> row_match);                                         // R7
    AST_CUR_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_active |-> ram_addr < ADDR_W'(TOTAL));                  // R8
    AST_ROW_KEEPS_ON_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_load && !row_up && !row_down) |=> $stable(cur_row));       // R9

endmodule

// File: tb/cursor_addr_unit_tb.sv
module cursor_addr_unit_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_load = 0, row_up = 0, row_down = 0;
    logic col_load = 0, col_up = 0, col_down = 0;
    logic [4:0] row_load_val = '0;
    logic [6:0] col_load_val = '0;
    logic refresh_active = 0;
    logic [4:0] disp_row = '0;
    logic [6:0] disp_col = '0;
    logic [4:0] cur_row, start_row;
    logic [6:0] cur_col, start_col;
    logic row_match;
    logic [10:0] ram_addr;

    int n_chk = 0;
    int n_fail = 0;
    int e_row = 0, e_col = 0, e_srow = 0, e_scol = 0;

    always #10 clk = ~clk;

    cursor_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .row_load(row_load), .row_up(row_up), .row_down(row_down),
        .row_load_val(row_load_val),
        .col_load(col_load), .col_up(col_up), .col_down(col_down),
        .col_load_val(col_load_val),
        .refresh_active(refresh_active), .disp_row(disp_row), .disp_col(disp_col),
        .cur_row(cur_row), .cur_col(cur_col),
        .start_row(start_row), .start_col(start_col),
        .row_match(row_match), .ram_addr(ram_addr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int step(input int v, input bit ld, input bit up,
                                input bit dn, input int lv, input int mx);
        if (ld)      return (lv > mx) ? mx : lv;
        else if (up) return (v == mx) ? 0 : v + 1;
        else if (dn) return (v == 0) ? mx : v - 1;
        return v;
    endfunction

    task automatic check_all();
        check("R2/R3/R4/R5/R9 row", cur_row, e_row);
        check("R2/R3/R4/R5/R9 col", cur_col, e_col);
        check("R6 start_row", start_row, e_srow);
        check("R6 start_col", start_col, e_scol);
        check("R7 row_match", row_match, (e_row == e_srow) ? 1 : 0);
        if (!refresh_active)
            check("R8 cursor addr", ram_addr, e_row * 80 + e_col);
    endtask

    // called just after a negedge; result sampled at the next negedge
    task automatic cyc(input bit rl, input bit ru, input bit rd, input int rv,
                       input bit cl, input bit cu, input bit cd, input int cv);
        row_load = rl; row_up = ru; row_down = rd; row_load_val = 5'(rv);
        col_load = cl; col_up = cu; col_down = cd; col_load_val = 7'(cv);
        @(negedge clk);
        e_row = step(e_row, rl, ru, rd, rv, 23);
        e_col = step(e_col, cl, cu, cd, cv, 79);
        if (rl) e_srow = e_row;
        if (cl) e_scol = e_col;
        row_load = 0; row_up = 0; row_down = 0;
        col_load = 0; col_up = 0; col_down = 0;
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cur_row", cur_row, 0);
        check("R1 cur_col", cur_col, 0);
        check("R1 start_row", start_row, 0);
        check("R1 start_col", start_col, 0);
        check("R1 row_match", row_match, 1);
        check("R1 ram_addr", ram_addr, 0);

        // R2 load sweep including clipping above the limits
        for (int v = 0; v < 128; v++)
            cyc(1, 0, 0, v % 32, 1, 0, 0, v);

        // R3 up sweep with wrap, R9 row untouched by column wrap
        cyc(1, 0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 85; i++) cyc(0, 0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, 0, 0, 0, 0);
        // R4 down sweep with wrap
        for (int i = 0; i < 85; i++) cyc(0, 0, 0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 30; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0);

        // R5 priority: every strobe combination on both axes
        for (int m = 0; m < 8; m++) begin
            cyc(1, 0, 0, 3, 1, 0, 0, 5);
            cyc(m[0], m[1], m[2], 10, m[0], m[1], m[2], 40);
            cyc(0, 0, 0, 0, 0, 0, 0, 0);
        end
        // boundaries under competing up/down
        cyc(1, 0, 0, 23, 1, 0, 0, 79);
        cyc(0, 1, 1, 0, 0, 1, 1, 0);
        cyc(0, 0, 1, 0, 0, 0, 1, 0);

        // R7 row_match follows the live row
        cyc(1, 0, 0, 7, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0, 0);

        // R8 display address sweep
        refresh_active = 1;
        for (int r = 0; r < 24; r++)
            for (int c = 0; c < 80; c++) begin
                disp_row = 5'(r); disp_col = 7'(c);
                #1;
                check("R8 display addr", ram_addr, r * 80 + c);
            end

        // R8 cursor steps while refresh owns the address
        disp_row = 5'd11; disp_col = 7'd33;
        cyc(0, 1, 0, 0, 0, 1, 0, 0);
        check("R8 refresh holds addr", ram_addr, 11 * 80 + 33);
        cyc(1, 0, 0, 20, 1, 0, 0, 61);
        check("R8 refresh holds addr", ram_addr, 11 * 80 + 33);
        refresh_active = 0;
        #1;
        check("R8 cursor addr after refresh", ram_addr, 20 * 80 + 61);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule